// File: doc/BRIEF.md
# Sampling Pipeline and Event Buffer Controller

This controller sequences a per-channel analog sample store built as a ring of sampling cells plus a small set of event slots. Free-running, it steps a write pointer around the ring once per programmable sampling period. The period is an integer count of system clock cycles. Its one-hot select tells the analog front end which cell captures the shaped waveform next.

When a trigger is accepted, the block freezes the ring contents into the next free event slot. It strobes which slot gets them and which cell holds the oldest sample. It also records the event's tags: a bunch-crossing time stamp and an 8-bit event number. Frozen slots wait in first-in first-out order for digitisation. A request/acknowledge pair hands the oldest one to the converter and frees the slot. A trigger that finds every slot occupied is lost and is counted in a saturating counter.

Top module: `sample_evbuf_ctrl`

## Requirements
- R1: After reset the cell select is 1 (cell 0), and the freeze strobe, read request, full flag and drop counter are all 0.
- R2: With period value P (P = 0 behaves as 1), the write pointer advances by one cell on every P-th active clock edge counted from reset. It wraps from NCELL-1 to 0. `cell_sel_o` is one-hot with bit k set when the pointer is k.
- R3: An accepted trigger raises `frz_stb_o` for exactly the cycle after its sampling edge. With the strobe come the slot index and the oldest cell, which is the pointer value just before that edge. The same cell index is later presented as `rd_cell_o`.
- R4: The time stamp stored with an event is the number of whole bunch-crossing periods (BC_DIV clock cycles each) elapsed from reset up to the sampling edge, modulo 2^TS_W.
- R5: The event number starts at 0 after reset and increments by one per accepted trigger only, modulo 2^EV_W.
- R6: Slots are allocated in index order 0,1,…,NEVT-1 and then wrap. They are read out in the same order. `rd_req_o` is high whenever at least one slot is held, with the head slot's index and tags on the read outputs.
- R7: `rd_ack_i` on an edge while `rd_req_o` is high releases the head slot. An acknowledge while nothing is held changes nothing.
- R8: `full_o` is high while all NEVT slots are held. A trigger sampled while full is dropped with no freeze strobe, even if an acknowledge arrives on the same edge.
- R9: Each dropped trigger increments `ovf_cnt_o`, which holds at 2^OVF_W-1.
- R10: A trigger and an acknowledge on the same edge, when not full, both take effect and leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger, sampled on each edge |
| period_i | input | PER_W | Sampling period in clock cycles (0 acts as 1) |
| rd_ack_i | input | 1 | Readout done, releases head slot |
| cell_sel_o | output | NCELL | One-hot select of the cell being written |
| frz_stb_o | output | 1 | One-cycle freeze strobe |
| frz_buf_o | output | log2(NEVT) | Slot receiving the frozen samples |
| frz_cell_o | output | log2(NCELL) | Oldest cell of the frozen samples |
| full_o | output | 1 | All slots held |
| ovf_cnt_o | output | OVF_W | Saturating count of dropped triggers |
| rd_req_o | output | 1 | Head slot awaiting digitisation |
| rd_buf_o | output | log2(NEVT) | Head slot index |
| rd_cell_o | output | log2(NCELL) | Head slot oldest cell |
| rd_ts_o | output | TS_W | Head slot time stamp |
| rd_ev_o | output | EV_W | Head slot event number |

## Verification
The ring pointer is swept across periods 0, 1, 2, 3, 5 and 15. Period 0 shows the minimum clamp, period 1 the fastest stepping, and the non-divisors of the crossing period separate the two dividers. Under each period, triggers and acknowledges arrive in interleaved residue patterns. Some edges carry both, which tells first-in first-out ordering and tag capture apart from slot reuse. A separate run fills every slot and keeps triggering past the counter's saturation point, including a trigger paired with an acknowledge while full. It then drains and acknowledges an empty store, confirming that dropped triggers consume no event number.

// File: rtl/sepc_pkg.sv
package sepc_pkg;
   // index width of a structure with n entries, never below one bit
   function automatic int idx_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/sepc_divider.sv
module sepc_divider #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] limit,
   output logic         tick
);
   logic [W-1:0] cnt;
   logic [W:0]   last;

   always_comb last = (limit == '0) ? '0 : ({1'b0, limit} - (W+1)'(1));
   assign tick = ({1'b0, cnt} >= last);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/sepc_ring.sv
module sepc_ring #(
   parameter  int N  = 8,
   localparam int PW = sepc_pkg::idx_w(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [PW-1:0] ptr,
   output logic [N-1:0]  sel
);
   logic [PW-1:0] nxt;

   generate
      if ((1 << PW) == N) begin : g_pow2
         assign nxt = ptr + PW'(1);
      end else begin : g_cmp
         assign nxt = (ptr == PW'(N-1)) ? '0 : ptr + PW'(1);
      end
      for (genvar k = 0; k < N; k++) begin : g_sel
         assign sel[k] = (ptr == PW'(k));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   ptr <= '0;
      else if (adv) ptr <= nxt;
   end
endmodule

// File: rtl/sepc_evq.sv
module sepc_evq #(
   parameter  int DEPTH = 8,
   parameter  int TW    = 8,
   localparam int IW    = sepc_pkg::idx_w(DEPTH),
   localparam int CNTW  = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [TW-1:0] push_tag,
   input  logic          pop,
   output logic [TW-1:0] head_tag,
   output logic [IW-1:0] wr_idx,
   output logic [IW-1:0] rd_idx,
   output logic          full,
   output logic          empty
);
   logic [TW-1:0]   mem [DEPTH];
   logic [CNTW-1:0] used;
   logic            do_push, do_pop;

   function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
      return (p == IW'(DEPTH-1)) ? '0 : p + IW'(1);
   endfunction

   assign full     = (used == CNTW'(DEPTH));
   assign empty    = (used == '0);
   assign do_push  = push && !full;
   assign do_pop   = pop && !empty;
   assign head_tag = mem[rd_idx];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_idx] <= push_tag;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_idx <= '0;
         rd_idx <= '0;
         used   <= '0;
      end else begin
         if (do_push) wr_idx <= bump(wr_idx);
         if (do_pop)  rd_idx <= bump(rd_idx);
         case ({do_push, do_pop})
            2'b10:   used <= used + CNTW'(1);
            2'b01:   used <= used - CNTW'(1);
            default: used <= used;
         endcase
      end
   end
endmodule

// File: rtl/sample_evbuf_ctrl.sv
module sample_evbuf_ctrl #(
   parameter  int NCELL  = 8,
   parameter  int NEVT   = 8,
   parameter  int PER_W  = 8,
   parameter  int BC_DIV = 36,
   parameter  int TS_W   = 16,
   parameter  int EV_W   = 8,
   parameter  int OVF_W  = 8,
   localparam int CW     = sepc_pkg::idx_w(NCELL),
   localparam int BW     = sepc_pkg::idx_w(NEVT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   input  logic [PER_W-1:0] period_i,
   input  logic             rd_ack_i,
   output logic [NCELL-1:0] cell_sel_o,
   output logic             frz_stb_o,
   output logic [BW-1:0]    frz_buf_o,
   output logic [CW-1:0]    frz_cell_o,
   output logic             full_o,
   output logic [OVF_W-1:0] ovf_cnt_o,
   output logic             rd_req_o,
   output logic [BW-1:0]    rd_buf_o,
   output logic [CW-1:0]    rd_cell_o,
   output logic [TS_W-1:0]  rd_ts_o,
   output logic [EV_W-1:0]  rd_ev_o
);
   localparam int BCW  = $clog2(BC_DIV + 1);
   localparam int TAGW = TS_W + EV_W + CW;
   localparam logic [BCW-1:0] BC_LIM = BCW'(BC_DIV);

   generate
      if (NCELL < 2)  begin : g_bad_ncell  $error("NCELL must be at least 2");  end
      if (NEVT < 2)   begin : g_bad_nevt   $error("NEVT must be at least 2");   end
      if (BC_DIV < 1) begin : g_bad_bcdiv  $error("BC_DIV must be positive");   end
      if (PER_W < 1 || TS_W < 1 || EV_W < 1 || OVF_W < 1) begin : g_bad_w
         $error("widths must be positive");
      end
   endgenerate

   logic            samp_tick, bc_tick;
   logic [CW-1:0]   cell_ptr;
   logic [TS_W-1:0] ts_q;
   logic [EV_W-1:0] ev_q;
   logic            q_full, q_empty, accept, release_head;
   logic [BW-1:0]   wr_idx, rd_idx;
   logic [TAGW-1:0] new_tag, head_tag;

   sepc_divider #(.W(PER_W)) u_samp_div (
      .clk(clk), .rst_n(rst_n), .limit(period_i), .tick(samp_tick));

   sepc_divider #(.W(BCW)) u_bc_div (
      .clk(clk), .rst_n(rst_n), .limit(BC_LIM), .tick(bc_tick));

   sepc_ring #(.N(NCELL)) u_ring (
      .clk(clk), .rst_n(rst_n), .adv(samp_tick), .ptr(cell_ptr), .sel(cell_sel_o));

   assign accept       = trig_i && !q_full;
   assign release_head = rd_ack_i && !q_empty;
   assign new_tag      = {ts_q, ev_q, cell_ptr};

   sepc_evq #(.DEPTH(NEVT), .TW(TAGW)) u_q (
      .clk(clk), .rst_n(rst_n), .push(accept), .push_tag(new_tag),
      .pop(release_head), .head_tag(head_tag), .wr_idx(wr_idx),
      .rd_idx(rd_idx), .full(q_full), .empty(q_empty));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ts_q       <= '0;
         ev_q       <= '0;
         ovf_cnt_o  <= '0;
         frz_stb_o  <= 1'b0;
         frz_buf_o  <= '0;
         frz_cell_o <= '0;
      end else begin
         if (bc_tick) ts_q <= ts_q + TS_W'(1);
         if (accept)  ev_q <= ev_q + EV_W'(1);
         if (trig_i && q_full && (ovf_cnt_o != '1)) ovf_cnt_o <= ovf_cnt_o + OVF_W'(1);
         frz_stb_o <= accept;
         if (accept) begin
            frz_buf_o  <= wr_idx;
            frz_cell_o <= cell_ptr;
         end
      end
   end

   assign full_o    = q_full;
   assign rd_req_o  = !q_empty;
   assign rd_buf_o  = rd_idx;
   assign rd_ts_o   = head_tag[TAGW-1 -: TS_W];
   assign rd_ev_o   = head_tag[CW +: EV_W];
   assign rd_cell_o = head_tag[CW-1:0];
endmodule

// File: rtl/sepc_chk.sv
module sepc_chk #(
   parameter int NCELL = 8,
   parameter int NEVT  = 8,
   parameter int EV_W  = 8,
   parameter int OVF_W = 8,
   parameter int BW    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             trig_i,
   input logic             rd_ack_i,
   input logic [NCELL-1:0] cell_sel_o,
   input logic             frz_stb_o,
   input logic             full_o,
   input logic [OVF_W-1:0] ovf_cnt_o,
   input logic             rd_req_o,
   input logic [BW-1:0]    rd_buf_o,
   input logic [EV_W-1:0]  rd_ev_o
);
   // R2
   cell_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cell_sel_o) == 1);

   // R3
   freeze_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && !full_o) |=> frz_stb_o);

   // R8
   no_freeze_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && full_o) |=> !frz_stb_o);

   // R9
   drop_count_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ovf_cnt_o >= $past(ovf_cnt_o));

   // R6
   head_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_buf_o) && $stable(rd_ev_o)));

   // R7
   idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_req_o && !trig_i) |=> !rd_req_o);
endmodule

bind sample_evbuf_ctrl sepc_chk #(
   .NCELL(NCELL), .NEVT(NEVT), .EV_W(EV_W), .OVF_W(OVF_W), .BW(BW)
) u_sepc_chk (
   .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .rd_ack_i(rd_ack_i),
   .cell_sel_o(cell_sel_o), .frz_stb_o(frz_stb_o), .full_o(full_o),
   .ovf_cnt_o(ovf_cnt_o), .rd_req_o(rd_req_o), .rd_buf_o(rd_buf_o),
   .rd_ev_o(rd_ev_o));

// File: tb/test_sample_evbuf_ctrl.sv
module test_sample_evbuf_ctrl;
   localparam int NCELL = 8, NEVT = 8, PER_W = 4, BC_DIV = 4;
   localparam int TS_W = 8, EV_W = 8, OVF_W = 8;

   logic clk = 1'b0, rst_n = 1'b0, trig_i = 1'b0, rd_ack_i = 1'b0;
   logic [PER_W-1:0] period_i = '0;
   logic [NCELL-1:0] cell_sel_o;
   logic frz_stb_o, full_o, rd_req_o;
   logic [2:0] frz_buf_o, frz_cell_o, rd_buf_o, rd_cell_o;
   logic [OVF_W-1:0] ovf_cnt_o;
   logic [TS_W-1:0] rd_ts_o;
   logic [EV_W-1:0] rd_ev_o;

   always #5 clk = ~clk;

   sample_evbuf_ctrl #(.NCELL(NCELL), .NEVT(NEVT), .PER_W(PER_W), .BC_DIV(BC_DIV),
      .TS_W(TS_W), .EV_W(EV_W), .OVF_W(OVF_W)) i_sample_evbuf_ctrl (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .period_i(period_i),
      .rd_ack_i(rd_ack_i), .cell_sel_o(cell_sel_o), .frz_stb_o(frz_stb_o),
      .frz_buf_o(frz_buf_o), .frz_cell_o(frz_cell_o), .full_o(full_o),
      .ovf_cnt_o(ovf_cnt_o), .rd_req_o(rd_req_o), .rd_buf_o(rd_buf_o),
      .rd_cell_o(rd_cell_o), .rd_ts_o(rd_ts_o), .rd_ev_o(rd_ev_o));

   int nvec = 0, nbad = 0;
   int edges, per_eff;
   int m_cnt, m_head, m_tail, m_ev, m_ovf;
   int q_ts [NEVT], q_ev [NEVT], q_cell [NEVT];
   bit e_frz; int e_frz_buf, e_frz_cell;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset(input int per);
      period_i = PER_W'(per);
      per_eff  = (per == 0) ? 1 : per;
      rst_n = 1'b0; trig_i = 1'b0; rd_ack_i = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      edges = 0; m_cnt = 0; m_head = 0; m_tail = 0; m_ev = 0; m_ovf = 0;
      // R1 reset state
      chk(cell_sel_o == 8'd1, "R1 cell_sel", int'(cell_sel_o), 1);
      chk(!frz_stb_o && !rd_req_o && !full_o, "R1 flags",
          int'({frz_stb_o, rd_req_o, full_o}), 0);
      chk(ovf_cnt_o == 0, "R1 ovf", int'(ovf_cnt_o), 0);
   endtask

   task automatic step(input bit trg, input bit ack);
      bit acc, pop;
      int pre_cell, pre_ts;
      trig_i = trg; rd_ack_i = ack;
      pre_cell = (edges / per_eff) % NCELL;
      pre_ts   = (edges / BC_DIV) % (1 << TS_W);
      acc = trg && (m_cnt < NEVT);
      pop = ack && (m_cnt > 0);
      if (trg && !acc && m_ovf < 255) m_ovf++;
      e_frz = acc; e_frz_buf = m_tail; e_frz_cell = pre_cell;
      if (pop) begin m_head = (m_head + 1) % NEVT; m_cnt--; end
      if (acc) begin
         q_ts[m_tail] = pre_ts; q_ev[m_tail] = m_ev; q_cell[m_tail] = pre_cell;
         m_ev = (m_ev + 1) % (1 << EV_W);
         m_tail = (m_tail + 1) % NEVT; m_cnt++;
      end
      @(posedge clk);
      edges++;
      @(negedge clk);
      trig_i = 1'b0; rd_ack_i = 1'b0;
      // R2 pointer position
      chk(cell_sel_o == NCELL'(1 << ((edges / per_eff) % NCELL)), "R2 cell_sel",
          int'(cell_sel_o), 1 << ((edges / per_eff) % NCELL));
      // R3 / R8 freeze strobe
      chk(frz_stb_o == e_frz, "R3/R8 frz_stb", int'(frz_stb_o), int'(e_frz));
      if (e_frz) begin
         chk(int'(frz_buf_o) == e_frz_buf, "R6 frz_buf", int'(frz_buf_o), e_frz_buf);
         chk(int'(frz_cell_o) == e_frz_cell, "R3 frz_cell", int'(frz_cell_o), e_frz_cell);
      end
      // R6 / R7 / R10 occupancy
      chk(rd_req_o == (m_cnt > 0), "R7/R10 rd_req", int'(rd_req_o), int'(m_cnt > 0));
      chk(full_o == (m_cnt == NEVT), "R8 full", int'(full_o), int'(m_cnt == NEVT));
      chk(int'(ovf_cnt_o) == m_ovf, "R9 ovf", int'(ovf_cnt_o), m_ovf);
      if (m_cnt > 0) begin
         chk(int'(rd_buf_o) == m_head, "R6 rd_buf", int'(rd_buf_o), m_head);
         chk(int'(rd_ts_o) == q_ts[m_head], "R4 rd_ts", int'(rd_ts_o), q_ts[m_head]);
         chk(int'(rd_ev_o) == q_ev[m_head], "R5 rd_ev", int'(rd_ev_o), q_ev[m_head]);
         chk(int'(rd_cell_o) == q_cell[m_head], "R3 rd_cell", int'(rd_cell_o), q_cell[m_head]);
      end
   endtask

   initial begin
      #3_000_000;
      nbad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      int pers [6] = '{0, 1, 2, 3, 5, 15};
      // sweep of sampling periods with interleaved trigger and ack patterns (R2..R7, R10)
      foreach (pers[p]) begin
         do_reset(pers[p]);
         for (int i = 0; i < 70; i++)
            step((i % 7 == 3) || (i % 11 == 0) || (i % 13 == 5), (i % 5 == 2));
      end
      // fill, saturate drop counter, drop with ack on full edge (R8, R9)
      do_reset(2);
      for (int i = 0; i < NEVT; i++) step(1'b1, 1'b0);
      for (int i = 0; i < 262; i++) step(1'b1, 1'b0);
      step(1'b1, 1'b1);
      // drain in order, then ack on empty store (R6, R7)
      for (int i = 0; i < NEVT + 2; i++) step(1'b0, 1'b1);
      // dropped triggers consumed no event number (R5)
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule